// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second operand of a 32-bit RISC datapath. It takes a source value, a shift kind, an 8-bit amount and the current carry flag. In the same cycle it returns the shifted operand and the carry that the shift produces. The ALU consumes the operand, and the flag logic takes the carry when the instruction updates flags.

The shifter supports five operations: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag. The carry rule depends on the kind and on the amount, with separate behaviour for an amount of zero, for exactly the word width, and for anything beyond it.

When the source register index names the program counter, the block uses the pipelined program-counter value instead of the register file value. That value is the fetch address plus 8 in the wide-instruction state, or plus 4 in the narrow-instruction state. The block has no state. Its outputs follow its inputs within the same cycle.

Top module: `opsh_top`

## Requirements
- R1: Kind codes select the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right by one through carry. Codes 5, 6 and 7 pass the source through unchanged, and the carry-out equals the carry-in.
- R2: The amount is the 8-bit value on `amount_i` (0 to 255). Every value in that range is legal.
- R3: For kinds 0 to 3, an amount of 0 returns the source unchanged, and the carry-out equals the carry-in.
- R4: Logical left by 1 to 32 returns the source shifted left with zero fill, and the carry-out is the last bit shifted out (source bit 32 minus amount). Any amount above 32 returns 0 with a carry-out of 0.
- R5: Logical right by 1 to 32 returns the source shifted right with zero fill, and the carry-out is source bit (amount minus 1). Any amount above 32 returns 0 with a carry-out of 0.
- R6: Arithmetic right by 1 to 32 fills from the sign bit, and the carry-out is source bit (amount minus 1). At 32 and above, every result bit equals source bit 31, and so does the carry-out.
- R7: Rotate right by a nonzero amount rotates by the amount modulo 32, and the carry-out equals bit 31 of the result. This includes amounts of 32, 64 and so on, which return the source unchanged.
- R8: Rotate through carry returns {carry-in, source[31:1]}, and the carry-out is source bit 0. The amount is ignored.
- R9: When `src_idx_i` is 15 and `narrow_i` is 0, the source is `pc_i` + 8. For any other index, the source is `src_val_i`.
- R10: When `src_idx_i` is 15 and `narrow_i` is 1, the source is `pc_i` + 4.
- R11: The block is combinational: the outputs reflect new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val_i | input | 32 | Register file value for the source |
| src_idx_i | input | 4 | Source register index; 15 selects the program counter |
| pc_i | input | 32 | Address of the current instruction |
| narrow_i | input | 1 | 1 in the narrow (16-bit) instruction state |
| kind_i | input | 3 | Shift kind code |
| amount_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state, so any fault appears on `result_o` or `carry_o` for the same input vector that triggers it. The fault can be seen without delay, but only at the amount that exercises it. The likely faults are a carry taken from a neighbouring bit, an off-by-one boundary at 32, and an adder offset that is wrong in one instruction state only. Each of these is limited to a narrow band of amounts or to one index value. For that reason, every amount from 0 to 255 is swept for every kind, over edge-heavy source patterns and both carry-in values, and the program-counter substitution is checked in both instruction states.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
    typedef enum logic [2:0] {
        SK_LSL  = 3'd0,
        SK_LSR  = 3'd1,
        SK_ASR  = 3'd2,
        SK_ROR  = 3'd3,
        SK_RRX  = 3'd4,
        SK_NOP5 = 3'd5,
        SK_NOP6 = 3'd6,
        SK_NOP7 = 3'd7
    } shift_kind_e;
endpackage

// File: rtl/opsh_src_sel.sv
module opsh_src_sel #(
    parameter int W      = 32,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15,
    parameter int WIDE_OFS   = 8,
    parameter int NARROW_OFS = 4
) (
    input  logic [W-1:0]     reg_val_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     pc_i,
    input  logic             narrow_i,
    output logic [W-1:0]     src_o
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);
    localparam logic [W-1:0]     OFS_W  = W'(WIDE_OFS);
    localparam logic [W-1:0]     OFS_N  = W'(NARROW_OFS);

    logic [W-1:0] pc_adj;

    always_comb begin
        pc_adj = pc_i + (narrow_i ? OFS_N : OFS_W);
        src_o  = (idx_i == PC_SEL) ? pc_adj : reg_val_i;
    end

    always_comb begin
        if (idx_i == PC_SEL && !narrow_i)
            a_r9_pc_wide: assert ((src_o - pc_i) == OFS_W);
        if (idx_i == PC_SEL && narrow_i)
            a_r10_pc_narrow: assert ((src_o - pc_i) == OFS_N);
        if (idx_i != PC_SEL)
            a_r9_reg_pass: assert (src_o == reg_val_i);
    end
endmodule

// File: rtl/opsh_core.sv
module opsh_core
    import opsh_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     src_i,
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             cin_i,
    output logic [W-1:0]     res_o,
    output logic             cout_o
);
    localparam int AW = $clog2(W);

    shift_kind_e kind;
    logic        amt_zero;

    logic [W:0]        lsl_ext;
    logic [W:0]        lsr_ext;
    logic signed [W:0] asr_in;
    logic signed [W:0] asr_ext;
    logic [AW-1:0]     rot_amt;
    logic [2*W-1:0]    rot_dbl;
    logic [W-1:0]      rot_res;

    always_comb begin
        kind     = shift_kind_e'(kind_i);
        amt_zero = (amt_i == '0);

        // left: carry lands one place above the word
        lsl_ext  = {1'b0, src_i} << amt_i;
        // right: carry lands one place below the word
        lsr_ext  = {src_i, 1'b0} >> amt_i;
        asr_in   = {src_i, 1'b0};
        asr_ext  = asr_in >>> amt_i;
        // rotation uses only the amount modulo the width
        rot_amt  = amt_i[AW-1:0];
        rot_dbl  = {src_i, src_i} >> rot_amt;
        rot_res  = rot_dbl[W-1:0];
    end

    always_comb begin
        res_o  = src_i;
        cout_o = cin_i;
        unique case (kind)
            SK_LSL: if (!amt_zero) begin
                res_o  = lsl_ext[W-1:0];
                cout_o = lsl_ext[W];
            end
            SK_LSR: if (!amt_zero) begin
                res_o  = lsr_ext[W:1];
                cout_o = lsr_ext[0];
            end
            SK_ASR: if (!amt_zero) begin
                res_o  = asr_ext[W:1];
                cout_o = asr_ext[0];
            end
            SK_ROR: if (!amt_zero) begin
                res_o  = rot_res;
                cout_o = rot_res[W-1];
            end
            SK_RRX: begin
                res_o  = {cin_i, src_i[W-1:1]};
                cout_o = src_i[0];
            end
            SK_NOP5, SK_NOP6, SK_NOP7: begin
                res_o  = src_i;
                cout_o = cin_i;
            end
        endcase
    end

    always_comb begin
        if (amt_zero && kind_i < 3'd4)
            a_r3_zero_pass: assert (res_o == src_i && cout_o == cin_i);
        if (kind == SK_LSL && int'(amt_i) > W)
            a_r4_lsl_over: assert (res_o == '0 && cout_o == 1'b0);
        if (kind == SK_LSR && int'(amt_i) > W)
            a_r5_lsr_over: assert (res_o == '0 && cout_o == 1'b0);
        if (kind == SK_ASR && int'(amt_i) >= W)
            a_r6_asr_fill: assert (res_o == {W{src_i[W-1]}} && cout_o == src_i[W-1]);
        if (kind == SK_ROR && !amt_zero)
            a_r7_ror_carry: assert (cout_o == res_o[W-1] && $countones(res_o) == $countones(src_i));
        if (kind == SK_RRX)
            a_r8_rrx: assert (res_o[W-1] == cin_i && cout_o == src_i[0]);
        if (kind_i > 3'd4)
            a_r1_reserved: assert (res_o == src_i && cout_o == cin_i);
    end
endmodule

// File: rtl/opsh_top.sv
module opsh_top #(
    parameter int W      = 32,
    parameter int AMT_W  = 8,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic [W-1:0]     src_val_i,
    input  logic [IDX_W-1:0] src_idx_i,
    input  logic [W-1:0]     pc_i,
    input  logic             narrow_i,
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic             carry_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o
);
    logic [W-1:0] src_sel;

    opsh_src_sel #(
        .W(W), .IDX_W(IDX_W), .PC_IDX(PC_IDX),
        .WIDE_OFS(8), .NARROW_OFS(4)
    ) u_src (
        .reg_val_i (src_val_i),
        .idx_i     (src_idx_i),
        .pc_i      (pc_i),
        .narrow_i  (narrow_i),
        .src_o     (src_sel)
    );

    opsh_core #(.W(W), .AMT_W(AMT_W)) u_core (
        .src_i  (src_sel),
        .kind_i (kind_i),
        .amt_i  (amount_i),
        .cin_i  (carry_i),
        .res_o  (result_o),
        .cout_o (carry_o)
    );
endmodule

// File: tb/sim_opsh_top.sv
module sim_opsh_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_val, pc;
    logic [3:0]  src_idx;
    logic        narrow, cin;
    logic [2:0]  kind;
    logic [7:0]  amt;
    logic [31:0] res;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opsh_top u0 (
        .src_val_i (src_val), .src_idx_i (src_idx), .pc_i (pc),
        .narrow_i (narrow), .kind_i (kind), .amount_i (amt),
        .carry_i (cin), .result_o (res), .carry_o (cout)
    );

    // bit-serial reference: one single-bit step per unit of amount
    function automatic void ref_shift(input logic [2:0] k, input logic [7:0] a,
                                      input logic [31:0] s, input logic c,
                                      output logic [31:0] r, output logic co);
        r  = s;
        co = c;
        case (k)
            3'd0: for (int i = 0; i < int'(a); i++) begin co = r[31]; r = {r[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < int'(a); i++) begin co = r[0]; r = {1'b0, r[31:1]}; end
            3'd2: for (int i = 0; i < int'(a); i++) begin co = r[0]; r = {r[31], r[31:1]}; end
            3'd3: if (a != 8'd0) begin
                for (int i = 0; i < int'(a) % 32; i++) r = {r[0], r[31:1]};
                co = r[31];
            end
            3'd4: begin co = s[0]; r = {c, s[31:1]}; end
            default: ;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] k, input logic [7:0] a);
        if (k > 3'd4) return "R1";
        if (k == 3'd4) return "R8";
        if (a == 8'd0) return "R3";
        case (k)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] er, input logic ec);
        checks++;
        if (res !== er || cout !== ec) begin
            errors++;
            $display("FAIL %s kind=%0d amt=%0d src=%h cin=%b: got %h/%b expected %h/%b",
                     req, kind, amt, src_val, cin, res, cout, er, ec);
        end
    endtask

    initial begin
        logic [31:0] pats [5];
        logic [31:0] er;
        logic        ec;
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h0000_0000;
        src_val = '0; pc = '0; src_idx = 4'd0; narrow = 1'b0;
        kind = 3'd0; amt = 8'd0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        check("R3", 32'h0, 1'b0);    // quiescent inputs: all-zero outputs

        // R11: change inputs mid-cycle, outputs follow without an edge
        @(posedge clk); #2;
        src_val = 32'h0000_00F0; kind = 3'd1; amt = 8'd4; #1;
        check("R11", 32'h0000_000F, 1'b0);

        // full sweep: R1..R8, R2 covers the whole 0..255 amount range
        for (int p = 0; p < 5; p++)
            for (int k = 0; k < 8; k++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 256; a++) begin
                        @(posedge clk); #2;
                        src_val = pats[p]; kind = 3'(k); amt = 8'(a); cin = 1'(c);
                        #1;
                        ref_shift(kind, amt, src_val, cin, er, ec);
                        check(a == 255 ? "R2" : req_of(kind, amt), er, ec);
                    end

        // R9 / R10: program counter substitution
        @(posedge clk); #2;
        src_val = 32'hDEAD_BEEF; pc = 32'h0000_1000; src_idx = 4'd15;
        narrow = 1'b0; kind = 3'd0; amt = 8'd0; cin = 1'b1; #1;
        check("R9", 32'h0000_1008, 1'b1);
        @(posedge clk); #2;
        narrow = 1'b1; #1;
        check("R10", 32'h0000_1004, 1'b1);
        @(posedge clk); #2;
        kind = 3'd0; amt = 8'd4; #1;             // (pc+4) << 4
        check("R10", 32'h0001_0040, 1'b0);
        @(posedge clk); #2;
        narrow = 1'b0; pc = 32'hFFFF_FFFC; kind = 3'd1; amt = 8'd1; #1; // wraps to 4
        check("R9", 32'h0000_0002, 1'b0);
        @(posedge clk); #2;
        src_idx = 4'd14; kind = 3'd0; amt = 8'd0; #1;
        check("R9", 32'hDEAD_BEEF, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule